// File: doc/BRIEF.md
# Inter-Frame Gap Timer

This block holds back a transmitter for a programmable number of bit times after a frame ends, so that the medium stays idle for at least that long between frames. Software writes an 8-bit gap value in bit times. The two lowest bits of that value have no effect, so the gap moves in steps of four bit times. After reset the value is 96 bit times. Values below that are applied as written, with no clamping.

The end of a frame is taken from a different signal in each duplex mode. In half-duplex it is the falling edge of carrier sense. In full-duplex it is the falling edge of the local transmit enable. After that event, the timer counts one step on each clock cycle in which the bit-time enable is high. Once the programmed number of bit times has passed, it raises the transmit-permitted output. That output stays high until activity resumes on the signal that the current mode watches. A transmit request is granted only while transmission is permitted.

Top module: `ifg_timer`

## Requirements
- R1: After reset the gap value is 0x60. In half-duplex, tx_permit rises at the clock edge that ends the 96th bit_tick cycle after the end-of-frame cycle, and stays low before that edge.
- R2: A write with gap_we high loads gap_din at the next clock edge. The value is used without clamping, so a gap of 8 permits transmission after 8 ticks.
- R3: The effective gap is the stored value with bits [1:0] forced to zero. A value of 0x13 gives the same 16-tick gap as 0x10.
- R4: In half-duplex (full_duplex=0) the end of a frame is a high-to-low transition of carrier_sense. Pulses on tx_enable leave tx_permit unchanged in this mode.
- R5: In full-duplex (full_duplex=1) the end of a frame is a high-to-low transition of tx_enable. Pulses on carrier_sense leave tx_permit unchanged in this mode.
- R6: The count advances only on cycles with bit_tick high. A tick in the end-of-frame cycle itself is not counted.
- R7: A new end-of-frame event before the gap expires drops tx_permit and restarts the count from zero.
- R8: tx_permit is low during the end-of-frame cycle and during every cycle in which the watched activity signal is high. Once it has risen after the gap, it stays high until that signal rises again.
- R9: An effective gap of zero raises tx_permit at the clock edge that ends the first bit_tick cycle after the end of the frame.
- R10: tx_grant equals tx_request AND tx_permit in every cycle.
- R11: After reset, with both activity signals low, tx_permit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gap_we | input | 1 | Write strobe for the gap value |
| gap_din | input | GAP_W (8) | Gap value in bit times |
| full_duplex | input | 1 | 1 selects full-duplex, 0 selects half-duplex |
| carrier_sense | input | 1 | Carrier present on the medium |
| tx_enable | input | 1 | Local transmitter is sending |
| bit_tick | input | 1 | One-cycle pulse per network bit time |
| tx_request | input | 1 | Request to start a transmission |
| tx_permit | output | 1 | The idle gap has elapsed and the medium is quiet |
| tx_grant | output | 1 | Request accepted in this cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit gap, a reset value of 0x60 and two ignored low bits. With these values the full 96-tick reset gap fits in a short run, and so do the small programmed gaps of 16, 8 and 0. Together they reach the masked-bit aliasing, the absence of clamping and the zero-gap boundary. Ticks are applied both back to back and every other cycle. This separates clock cycles from bit times and shows that the restart after an early end-of-frame counts from zero.

// File: rtl/ifg_timer.sv
module ifg_timer #(
  parameter int GAP_W = 8,
  parameter logic [GAP_W-1:0] RST_GAP = 8'h60,
  parameter int DROP_LSB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gap_we,
  input  logic [GAP_W-1:0] gap_din,
  input  logic             full_duplex,
  input  logic             carrier_sense,
  input  logic             tx_enable,
  input  logic             bit_tick,
  input  logic             tx_request,
  output logic             tx_permit,
  output logic             tx_grant
);
  localparam int CNT_W = GAP_W + 1;
  localparam logic [GAP_W-1:0] KEEP_MASK = {GAP_W{1'b1}} << DROP_LSB;

  logic [GAP_W-1:0] gap_q, cnt;
  logic             cs_q, te_q, done;
  logic [GAP_W-1:0] eff_gap;
  logic [CNT_W-1:0] cnt_nxt;
  logic             act, eof, reach;

  assign eff_gap = gap_q & KEEP_MASK;
  assign act     = full_duplex ? tx_enable : carrier_sense;
  assign eof     = full_duplex ? (te_q & ~tx_enable) : (cs_q & ~carrier_sense);
  assign cnt_nxt = {1'b0, cnt} + CNT_W'(1);
  assign reach   = cnt_nxt >= {1'b0, eff_gap};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gap_q <= RST_GAP;
    else if (gap_we) gap_q <= gap_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b0;
      te_q <= 1'b0;
    end else begin
      cs_q <= carrier_sense;
      te_q <= tx_enable;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (eof) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done && bit_tick) begin
      if (reach) done <= 1'b1;
      else       cnt  <= cnt_nxt[GAP_W-1:0];
    end

  assign tx_permit = done & ~act & ~eof;
  assign tx_grant  = tx_request & tx_permit;

  // R4
  eof_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && cs_q && !carrier_sense) |=> !done);

  // R5
  eof_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && te_q && !tx_enable) |=> !done);

  // R6
  tick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bit_tick));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ($past(bit_tick) || $past(eof)));
endmodule

// File: tb/test_ifg_timer.sv
`timescale 1ns/1ps
module test_ifg_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gap_we = 1'b0, full_duplex = 1'b0, carrier_sense = 1'b0;
  logic tx_enable = 1'b0, bit_tick = 1'b0, tx_request = 1'b0;
  logic [7:0] gap_din = 8'h00;
  logic tx_permit, tx_grant;

  typedef struct { string tag; bit perm; bit grant; } item_t;
  item_t sbq[$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ifg_timer i_ifg_timer (
    .clk(clk), .rst_n(rst_n), .gap_we(gap_we), .gap_din(gap_din),
    .full_duplex(full_duplex), .carrier_sense(carrier_sense),
    .tx_enable(tx_enable), .bit_tick(bit_tick), .tx_request(tx_request),
    .tx_permit(tx_permit), .tx_grant(tx_grant));

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      total++;
      if (tx_permit !== it.perm || tx_grant !== it.grant) begin
        bad++;
        $display("FAIL %s: permit=%b grant=%b expected permit=%b grant=%b",
                 it.tag, tx_permit, tx_grant, it.perm, it.grant);
      end
    end
  end

  task automatic drv(input string tag, input bit cs, input bit te,
                     input bit tk, input bit rq, input bit ep);
    @(posedge clk); #1;
    gap_we = 1'b0; carrier_sense = cs; tx_enable = te;
    bit_tick = tk; tx_request = rq;
    sbq.push_back('{tag, ep, rq & ep});
  endtask

  task automatic wr(input logic [7:0] v);
    @(posedge clk); #1;
    gap_we = 1'b1; gap_din = v; carrier_sense = 1'b0; tx_enable = 1'b0;
    bit_tick = 1'b0; tx_request = 1'b0;
    sbq.push_back('{"R2", 1'b1, 1'b0});
  endtask

  task automatic act(input string tag, input bit lvl, input bit tk, input bit ep);
    if (full_duplex) drv(tag, 1'b0, lvl, tk, 1'b0, ep);
    else             drv(tag, lvl, 1'b0, tk, 1'b0, ep);
  endtask

  task automatic frame_gap(input string tag, input int k);
    for (int i = 0; i < 3; i++) act("R8", 1'b1, 1'b1, 1'b0);
    act("R6", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < k; i++) act(tag, 1'b0, 1'b1, 1'b0);
    act(tag, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    drv("R11", 0, 0, 0, 0, 1);
    drv("R10", 0, 0, 0, 1, 1);
    drv("R10", 0, 0, 0, 0, 1);
    frame_gap("R1", 96);
    drv("R8", 0, 0, 1, 1, 1);
    wr(8'h13);
    frame_gap("R3", 16);
    wr(8'h10);
    frame_gap("R3", 16);
    wr(8'h08);
    frame_gap("R2", 8);
    act("R8", 1'b1, 1'b0, 1'b0);
    act("R6", 1'b0, 1'b1, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      act("R6", 1'b0, 1'b1, 1'b0);
      act("R6", 1'b0, 1'b0, i == 8);
    end
    for (int i = 0; i < 2; i++) drv("R4", 0, 1, 1, 0, 1);
    drv("R4", 0, 0, 1, 0, 1);
    drv("R4", 0, 0, 1, 1, 1);
    act("R7", 1'b1, 1'b0, 1'b0);
    act("R7", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) act("R7", 1'b0, 1'b1, 1'b0);
    act("R7", 1'b1, 1'b0, 1'b0);
    act("R7", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) act("R7", 1'b0, 1'b1, 1'b0);
    act("R7", 1'b0, 1'b0, 1'b1);
    full_duplex = 1'b1;
    for (int i = 0; i < 2; i++) drv("R5", 1, 0, 1, 0, 1);
    drv("R5", 0, 0, 1, 0, 1);
    drv("R5", 0, 0, 1, 1, 1);
    frame_gap("R5", 8);
    wr(8'h03);
    frame_gap("R9", 1);
    drv("R10", 0, 0, 0, 1, 1);
    full_duplex = 1'b0;
    frame_gap("R9", 1);
    drv("R10", 0, 0, 0, 0, 1);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule